// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the memory address of a load or store from operands that decode and the register file have already produced. A mode selector chooses among five ways of combining a base value, an index value, a displacement and the program counter: the displacement alone, base plus displacement, base plus index, base plus a power-of-two scaled index plus displacement, and program counter plus displacement. The displacement arrives as a raw field whose width is 8, 16 or 32 bits. It is sign-extended to the address width before any addition.

The result is registered in a single pipeline stage. A valid strobe travels with the operands and comes out one clock later beside the address. Next to the address the block reports whether it is misaligned for the requested access size, so a later stage can trap or split the access. All sums wrap modulo 2^32 and no carry or overflow is reported.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 0 yields the extended displacement alone, ignoring base, index and program counter.
- R2: Mode code 1 yields base plus the extended displacement.
- R3: Mode code 2 yields base plus index; the displacement has no effect.
- R4: Mode code 3 yields base plus index shifted left by the scale code (0=x1, 1=x2, 2=x4, 3=x8) plus the extended displacement.
- R5: Mode code 4 yields program counter plus the extended displacement.
- R6: Displacement width code 0 sign-extends bits 7:0, code 1 sign-extends bits 15:0, codes 2 and 3 use all 32 bits; bits above the selected width have no effect.
- R7: Every sum and the scaled index wrap modulo 2^32 without any indication.
- R8: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R9: The misaligned flag is 0 for size code 0 (byte), equals address bit 0 for size code 1 (halfword), and is set when address bits 1:0 are nonzero for size codes 2 and 3 (word).
- R10: The output valid equals the input valid of the previous clock; synchronous reset clears the output valid, address and flag.
- R11: A clock with input valid low leaves the output address and misaligned flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this clock are to be processed |
| mode | input | 3 | Address mode code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Raw displacement field, right-aligned |
| disp_sel | input | 2 | Displacement width code |
| pc | input | 32 | Program counter of the access |
| acc_size | input | 2 | Access size code |
| out_valid | output | 1 | Address result valid |
| out_addr | output | 32 | Effective address |
| out_misalign | output | 1 | Address misaligned for the access size |

## Verification
Every computation lands in one register, so a wrong mode choice, extension width or shift shows on out_addr exactly one clock after the operands are accepted, and the table walk compares each such value against a hand-derived address. A misaligned flag computed from the wrong address bits shows in that same cycle on out_misalign. A broken valid pipeline or a capture enable that ignores in_valid shows in the cycle right after an idle clock, as a spurious out_valid or as an address that changed while no operands were offered.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned SCALE_W = 2;
  localparam int unsigned DSEL_W  = 2;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned MID_W    = 16;

  typedef enum logic [MODE_W-1:0] {
    EA_ABS    = 3'd0,
    EA_BDISP  = 3'd1,
    EA_BIDX   = 3'd2,
    EA_SCALED = 3'd3,
    EA_PCREL  = 3'd4
  } ea_mode_e;

  typedef enum logic [DSEL_W-1:0] {
    DW_8  = 2'd0,
    DW_16 = 2'd1,
    DW_32 = 2'd2,
    DW_32B = 2'd3
  } disp_w_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDB = 2'd3
  } acc_size_e;

  function automatic logic [ADDR_W-1:0] sext_narrow(input logic [NARROW_W-1:0] v);
    return {{(ADDR_W-NARROW_W){v[NARROW_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] sext_mid(input logic [MID_W-1:0] v);
    return {{(ADDR_W-MID_W){v[MID_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] scale_idx(input logic [ADDR_W-1:0] v,
                                                  input logic [SCALE_W-1:0] sh);
    return v << sh;
  endfunction

  function automatic logic misalign_of(input logic [1:0] low, input acc_size_e sz);
    logic r;
    case (sz)
      SZ_BYTE: r = 1'b0;
      SZ_HALF: r = low[0];
      default: r = |low;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
  import eag_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic [W-1:0]      disp_raw,
  input  logic [DSEL_W-1:0] sel,
  output logic [W-1:0]      disp_ext
);
  disp_w_e sel_e;
  assign sel_e = disp_w_e'(sel);

  always_comb begin
    case (sel_e)
      DW_8:    disp_ext = sext_narrow(disp_raw[NARROW_W-1:0]);
      DW_16:   disp_ext = sext_mid(disp_raw[MID_W-1:0]);
      default: disp_ext = disp_raw;
    endcase
  end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [W-1:0]       base,
  input  logic [W-1:0]       index,
  input  logic [SCALE_W-1:0] scale,
  input  logic [W-1:0]       disp_ext,
  input  logic [W-1:0]       pc,
  output logic [W-1:0]       ea
);
  ea_mode_e   mode_e;
  logic [W-1:0] term_anchor;
  logic [W-1:0] term_index;
  logic [W-1:0] term_disp;
  logic [W-1:0] idx_scaled;

  assign mode_e     = ea_mode_e'(mode);
  assign idx_scaled = scale_idx(index, scale);

  always_comb begin
    term_anchor = '0;
    term_index  = '0;
    term_disp   = disp_ext;
    case (mode_e)
      EA_BDISP:  term_anchor = base;
      EA_BIDX: begin
        term_anchor = base;
        term_index  = index;
        term_disp   = '0;
      end
      EA_SCALED: begin
        term_anchor = base;
        term_index  = idx_scaled;
      end
      EA_PCREL:  term_anchor = pc;
      default:   term_anchor = '0;
    endcase
  end

  assign ea = term_anchor + term_index + term_disp;
endmodule

// File: rtl/eag_align_chk.sv
module eag_align_chk
  import eag_pkg::*;
(
  input  logic [1:0]        addr_low,
  input  logic [SIZE_W-1:0] size,
  output logic              misalign
);
  assign misalign = misalign_of(addr_low, acc_size_e'(size));
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MODE_W-1:0]  mode,
  input  logic [AW-1:0]      base,
  input  logic [AW-1:0]      index,
  input  logic [SCALE_W-1:0] scale,
  input  logic [AW-1:0]      disp,
  input  logic [DSEL_W-1:0]  disp_sel,
  input  logic [AW-1:0]      pc,
  input  logic [SIZE_W-1:0]  acc_size,
  output logic               out_valid,
  output logic [AW-1:0]      out_addr,
  output logic               out_misalign
);
  logic [AW-1:0] disp_x;
  logic [AW-1:0] ea_next;
  logic          mis_next;

  eag_disp_ext #(.W(AW)) u_ext (
    .disp_raw (disp),
    .sel      (disp_sel),
    .disp_ext (disp_x)
  );

  eag_addr_calc #(.W(AW)) u_calc (
    .mode     (mode),
    .base     (base),
    .index    (index),
    .scale    (scale),
    .disp_ext (disp_x),
    .pc       (pc),
    .ea       (ea_next)
  );

  eag_align_chk u_align (
    .addr_low (ea_next[1:0]),
    .size     (acc_size),
    .misalign (mis_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_misalign <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr     <= ea_next;
        out_misalign <= mis_next;
      end
    end
  end
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk
  import eag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [MODE_W-1:0]  mode,
  input logic [AW-1:0]      base,
  input logic [AW-1:0]      index,
  input logic [AW-1:0]      disp,
  input logic [DSEL_W-1:0]  disp_sel,
  input logic [AW-1:0]      pc,
  input logic [SIZE_W-1:0]  acc_size,
  input logic               out_valid,
  input logic [AW-1:0]      out_addr,
  input logic               out_misalign
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_addr) && $stable(out_misalign))); // R11
  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_size == 2'd0) |=> !out_misalign); // R9
  AST_HALF_BIT0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_size == 2'd1) |=> (out_misalign == out_addr[0])); // R9
  AST_INDEX_SUM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd2) |=> (out_addr == $past(base) + $past(index))); // R3
  AST_PC_FULL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd4 && disp_sel[1]) |=> (out_addr == $past(pc) + $past(disp))); // R5
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .mode         (mode),
  .base         (base),
  .index        (index),
  .disp         (disp),
  .disp_sel     (disp_sel),
  .pc           (pc),
  .acc_size     (acc_size),
  .out_valid    (out_valid),
  .out_addr     (out_addr),
  .out_misalign (out_misalign)
);

// File: tb/sim_eff_addr_gen.sv
`timescale 1ns/1ps
module sim_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  mode;
  logic [31:0] base, index, disp, pc;
  logic [1:0]  scale, disp_sel, acc_size;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_misalign;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  eff_addr_gen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
    .index(index), .scale(scale), .disp(disp), .disp_sel(disp_sel), .pc(pc),
    .acc_size(acc_size), .out_valid(out_valid), .out_addr(out_addr),
    .out_misalign(out_misalign)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [31:0] b;
    logic [31:0] x;
    logic [1:0]  sc;
    logic [31:0] d;
    logic [1:0]  ds;
    logic [31:0] p;
    logic [1:0]  sz;
    logic [31:0] ea;
    logic        mis;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 32'h1234_5678, 32'h0000_0099, 2'd0, 32'h0000_0040, 2'd2, 32'h0000_7000, 2'd2, 32'h0000_0040, 1'b0, "R1"},
    '{3'd0, 32'h0000_0000, 32'h0000_0000, 2'd0, 32'h1234_56F0, 2'd0, 32'h0000_0000, 2'd2, 32'hFFFF_FFF0, 1'b0, "R6"},
    '{3'd1, 32'h0000_1000, 32'h0000_0000, 2'd0, 32'h0000_8004, 2'd1, 32'h0000_0000, 2'd1, 32'hFFFF_9004, 1'b0, "R2"},
    '{3'd1, 32'h0000_2000, 32'h0000_0000, 2'd0, 32'h0000_0007, 2'd0, 32'h0000_0000, 2'd1, 32'h0000_2007, 1'b1, "R9"},
    '{3'd2, 32'h0000_0100, 32'h0000_0023, 2'd3, 32'h0000_5555, 2'd2, 32'h0000_0000, 2'd0, 32'h0000_0123, 1'b0, "R3"},
    '{3'd3, 32'h0000_1000, 32'h0000_0010, 2'd3, 32'h0000_0008, 2'd0, 32'h0000_0000, 2'd2, 32'h0000_1088, 1'b0, "R4"},
    '{3'd3, 32'h0000_1000, 32'h0000_0010, 2'd1, 32'h0000_00FE, 2'd0, 32'h0000_0000, 2'd2, 32'h0000_101E, 1'b1, "R4"},
    '{3'd3, 32'h0000_0000, 32'h0000_0005, 2'd0, 32'h0000_0000, 2'd2, 32'h0000_0000, 2'd3, 32'h0000_0005, 1'b1, "R9"},
    '{3'd4, 32'h0000_0AAA, 32'h0000_0000, 2'd0, 32'h0000_FFFC, 2'd1, 32'h0040_0000, 2'd2, 32'h003F_FFFC, 1'b0, "R5"},
    '{3'd1, 32'hFFFF_FFF0, 32'h0000_0000, 2'd0, 32'h0000_0020, 2'd2, 32'h0000_0000, 2'd2, 32'h0000_0010, 1'b0, "R7"},
    '{3'd3, 32'h8000_0000, 32'h8000_0000, 2'd2, 32'h0000_0000, 2'd2, 32'h0000_0000, 2'd2, 32'h8000_0000, 1'b0, "R7"},
    '{3'd5, 32'h0000_0999, 32'h0000_0011, 2'd1, 32'h0000_0044, 2'd2, 32'h0000_3000, 2'd2, 32'h0000_0044, 1'b0, "R8"},
    '{3'd7, 32'h0000_0999, 32'h0000_0011, 2'd1, 32'h0000_0081, 2'd0, 32'h0000_3000, 2'd1, 32'hFFFF_FF81, 1'b1, "R8"},
    '{3'd0, 32'h0000_0000, 32'h0000_0000, 2'd0, 32'h0000_00AB, 2'd3, 32'h0000_0000, 2'd0, 32'h0000_00AB, 1'b0, "R6"}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    mode = v.m; base = v.b; index = v.x; scale = v.sc; disp = v.d;
    disp_sel = v.ds; pc = v.p; acc_size = v.sz; in_valid = vld;
  endtask

  initial begin
    rst = 1'b1;
    drive(TBL[0], 1'b0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset addr", out_addr, 32'd0);
    chk("R10 reset flag", {31'd0, out_misalign}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      chk({TBL[i].tag, " addr"}, out_addr, TBL[i].ea);
      chk({TBL[i].tag, " misalign"}, {31'd0, out_misalign}, {31'd0, TBL[i].mis});
      chk("R10 valid out", {31'd0, out_valid}, 32'd1);
    end

    // R11: idle clock with different operands leaves result unchanged
    drive(TBL[2], 1'b0);
    @(negedge clk);
    chk("R10 valid drops", {31'd0, out_valid}, 32'd0);
    chk("R11 addr held", out_addr, TBL[NV-1].ea);
    chk("R11 flag held", {31'd0, out_misalign}, 32'd0);

    // R6: bits above the 16-bit field are ignored
    drive(TBL[8], 1'b1);
    disp = 32'hABCD_FFFC;
    @(negedge clk);
    chk("R6 upper disp bits ignored", out_addr, 32'h003F_FFFC);

    // R3: displacement has no effect in mode 2
    drive(TBL[4], 1'b1);
    disp = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R3 disp ignored", out_addr, 32'h0000_0123);

    // R10: reset in the middle of traffic clears output
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 mid reset addr", out_addr, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule